// File: doc/BRIEF.md
# Selective Compressed Scan Decompressor

This block sits in front of the serial input of a normal scan chain and supplies that chain one bit per cycle. At the start of each test pattern a mode bit picks one of two ways to load it. In bypass mode every serial bit goes straight through to the chain in the same cycle. In compressed mode the pattern is handled as a run of 4-bit columns followed by zero to three residual bits. For each column, a short code arrives on the serial input. A per-column lookup table expands that code into the 4-bit segment the chain needs.

Every column has its own code width and its own table. The tables are built offline: leftover don't-care bits are set to 0 before the distinct segments are numbered. A column whose width is outside the coded range is forwarded raw, four bits unchanged. The residual bits are always forwarded raw. While a decoded segment drains into the chain, the serial input is held off through its ready signal. The tables are written through a simple port, and only while no pattern is active.

Top module: `scan_decomp`

## Requirements
- R1: After reset, si_ready, so_valid, seg_done, pat_done and dec_err are all low. Every column width reads 0 and no table entry is loaded.
- R2: In bypass mode (pat_compress=0), each accepted serial bit appears on so_data with so_valid high in the same cycle. Exactly 4*pat_cols+pat_resid bits are forwarded, and seg_done stays low.
- R3: In compressed mode, a column whose width w lies between 1 and CODE_W_MAX takes w code bits, most significant first. Over the next 4 cycles it emits the table segment for (column, code), bit 3 first.
- R4: While a decoded segment drains, si_ready is low. With si_valid held high, a coded column takes w+4 cycles and a raw column takes 4.
- R5: A column whose width is 0 or above CODE_W_MAX forwards its 4 serial bits unchanged.
- R6: In compressed mode the pat_resid residual bits (0 to 3) follow the last column and are forwarded unchanged.
- R7: In compressed mode seg_done pulses on the last output bit of every column, coded or raw, and never on residual bits.
- R8: pat_done is a one-cycle pulse in the cycle after the last output bit, or in the cycle after pat_start for an empty pattern. The block then returns to idle.
- R9: A code whose table entry was never loaded decodes as 0000 and sets dec_err, which stays high until reset.
- R10: Table and width writes, and pat_start, are ignored while a pattern is active.
- R11: A cycle with si_valid low consumes nothing and emits nothing on the serial paths.

States: IDLE (writes allowed, waits for pat_start), PASS (bypass column), GATHER (collect code bits), DRAIN (emit decoded segment), RAW (raw column), RESID (residual bits), DONE (pat_done pulse). Transitions:
- IDLE→PASS, GATHER, RAW, RESID or DONE on pat_start.
- The end of each column goes to the next column's state, to RESID, or to DONE.
- GATHER→DRAIN on the last code bit.
- RESID→DONE on the last residual bit.
- DONE→IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width_we | input | 1 | Write enable for a column's code width |
| cfg_lut_we | input | 1 | Write enable for one table entry |
| cfg_col | input | COL_AW | Column addressed by a write |
| cfg_width | input | 3 | Code width to write |
| cfg_code | input | CODE_W_MAX | Code value addressed by a table write |
| cfg_seg | input | 4 | Segment stored for that code |
| pat_start | input | 1 | Starts a pattern (used only when idle) |
| pat_compress | input | 1 | 1 selects compressed mode, 0 selects bypass |
| pat_cols | input | COL_AW+1 | Number of 4-bit columns (clamped to N_COLS) |
| pat_resid | input | 2 | Number of residual bits |
| si_valid | input | 1 | Serial input bit valid |
| si_data | input | 1 | Serial input bit |
| si_ready | output | 1 | Block can accept a serial bit |
| so_valid | output | 1 | Bit for the normal chain valid |
| so_data | output | 1 | Bit for the normal chain |
| seg_done | output | 1 | Last bit of a compressed-mode column |
| pat_done | output | 1 | Pattern finished |
| dec_err | output | 1 | Sticky flag: an unloaded code was seen |

## Verification
The bench builds the block with N_COLS=4 and CODE_W_MAX=3. At that size every code of every table (eight entries per column) can be decoded within one short sweep. The sweep also walks column 0 through all eight width field values, so the coded range and both raw cases (0 and above 3) are covered exhaustively. The small column count lets every residual length and pattern shape be paired with both modes and with gaps in si_valid. It also makes reaching the column limit cheap.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;

    localparam int SEG_W = 4;   // normal-chain bits per column
    localparam int WID_W = 3;   // width field of a column

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PASS,
        ST_GATHER,
        ST_DRAIN,
        ST_RAW,
        ST_RESID,
        ST_DONE
    } dcmp_state_e;

endpackage

// File: rtl/dcmp_tables.sv
module dcmp_tables
    import dcmp_pkg::*;
#(
    parameter int N_COLS     = 16,
    parameter int CODE_W_MAX = 3,
    localparam int COL_AW    = $clog2(N_COLS),
    localparam int IDX_W     = COL_AW + CODE_W_MAX,
    localparam int SLOTS     = 1 << IDX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_open,
    input  logic                  width_we,
    input  logic                  lut_we,
    input  logic [COL_AW-1:0]     cfg_col,
    input  logic [WID_W-1:0]      cfg_width,
    input  logic [CODE_W_MAX-1:0] cfg_code,
    input  logic [SEG_W-1:0]      cfg_seg,
    input  logic [COL_AW-1:0]     rd_col,
    input  logic [CODE_W_MAX-1:0] rd_code,
    input  logic [COL_AW-1:0]     pk_col,
    output logic [WID_W-1:0]      cur_width,
    output logic [WID_W-1:0]      pk_width,
    output logic [SEG_W-1:0]      lut_seg,
    output logic                  lut_hit
);

    localparam logic [COL_AW:0] NCOL_L = (COL_AW+1)'(N_COLS);

    logic [N_COLS-1:0][WID_W-1:0] width_q;
    logic [SLOTS-1:0]             ent_vld;
    logic [SLOTS-1:0][SEG_W-1:0]  ent_seg;
    logic [IDX_W-1:0]             wr_idx;
    logic [IDX_W-1:0]             rd_idx;

    // one width register per column
    genvar gc;
    generate
        for (gc = 0; gc < N_COLS; gc++) begin : g_width
            logic [WID_W-1:0] w_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    w_q <= '0;
                end else if (cfg_open && width_we && (cfg_col == COL_AW'(gc))) begin
                    w_q <= cfg_width;
                end
            end
            assign width_q[gc] = w_q;
        end
    endgenerate

    assign wr_idx = {cfg_col, cfg_code};
    assign rd_idx = {rd_col, rd_code};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_vld <= '0;
            ent_seg <= '0;
        end else if (cfg_open && lut_we) begin
            ent_vld[wr_idx] <= 1'b1;
            ent_seg[wr_idx] <= cfg_seg;
        end
    end

    assign cur_width = width_q[rd_col];
    assign pk_width  = ({1'b0, pk_col} < NCOL_L) ? width_q[pk_col] : '0;
    assign lut_seg   = ent_seg[rd_idx];
    assign lut_hit   = ent_vld[rd_idx];

    // storage must not move while a pattern runs
    assert_closed_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> ($stable(width_q) && $stable(ent_vld) && $stable(ent_seg)));

endmodule

// File: rtl/dcmp_ctrl.sv
module dcmp_ctrl
    import dcmp_pkg::*;
#(
    parameter int N_COLS     = 16,
    parameter int CODE_W_MAX = 3,
    localparam int COL_AW    = $clog2(N_COLS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pat_start,
    input  logic                  pat_compress,
    input  logic [COL_AW:0]       pat_cols,
    input  logic [1:0]            pat_resid,
    input  logic                  si_valid,
    input  logic                  si_data,
    input  logic [WID_W-1:0]      cur_width,
    input  logic [WID_W-1:0]      pk_width,
    input  logic [SEG_W-1:0]      lut_seg,
    input  logic                  lut_hit,
    output logic [COL_AW-1:0]     rd_col,
    output logic [COL_AW-1:0]     pk_col,
    output logic [CODE_W_MAX-1:0] rd_code,
    output logic                  cfg_open,
    output logic                  si_ready,
    output logic                  so_valid,
    output logic                  so_data,
    output logic                  seg_done,
    output logic                  pat_done,
    output logic                  dec_err
);

    localparam logic [COL_AW:0] NCOL_L = (COL_AW+1)'(N_COLS);
    localparam logic [COL_AW:0] ONE_L  = (COL_AW+1)'(1);

    dcmp_state_e           state_q, state_d;
    logic [COL_AW-1:0]     col_q, col_d;
    logic [COL_AW:0]       left_q, left_d;
    logic [1:0]            resid_q, resid_d;
    logic [WID_W-1:0]      bit_q, bit_d;
    logic [CODE_W_MAX-1:0] code_q, code_d;
    logic [SEG_W-1:0]      seg_q, seg_d;
    logic                  mode_q, mode_d;
    logic                  err_q, err_d;

    logic [CODE_W_MAX:0]   code_ext;
    logic [CODE_W_MAX-1:0] code_nxt;
    logic [COL_AW:0]       cols_clamp;
    logic                  comp_eff;
    logic                  advance;
    dcmp_state_e           col_entry;

    function automatic logic is_coded(input logic [WID_W-1:0] w);
        return (w != '0) && (int'(w) <= CODE_W_MAX);
    endfunction

    assign code_ext   = {code_q, si_data};
    assign code_nxt   = code_ext[CODE_W_MAX-1:0];
    assign cols_clamp = (pat_cols > NCOL_L) ? NCOL_L : pat_cols;
    assign comp_eff   = (state_q == ST_IDLE) ? pat_compress : mode_q;
    assign col_entry  = !comp_eff ? ST_PASS : (is_coded(pk_width) ? ST_GATHER : ST_RAW);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            col_q   <= '0;
            left_q  <= '0;
            resid_q <= '0;
            bit_q   <= '0;
            code_q  <= '0;
            seg_q   <= '0;
            mode_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            col_q   <= col_d;
            left_q  <= left_d;
            resid_q <= resid_d;
            bit_q   <= bit_d;
            code_q  <= code_d;
            seg_q   <= seg_d;
            mode_q  <= mode_d;
            err_q   <= err_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        col_d   = col_q;
        left_d  = left_q;
        resid_d = resid_q;
        bit_d   = bit_q;
        code_d  = code_q;
        seg_d   = seg_q;
        mode_d  = mode_q;
        err_d   = err_q;
        advance = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pat_start) begin
                    mode_d  = pat_compress;
                    resid_d = pat_resid;
                    col_d   = '0;
                    bit_d   = '0;
                    code_d  = '0;
                    left_d  = cols_clamp;
                    if (cols_clamp != '0)      state_d = col_entry;
                    else if (pat_resid != '0)  state_d = ST_RESID;
                    else                       state_d = ST_DONE;
                end
            end
            ST_PASS, ST_RAW: begin
                if (si_valid) begin
                    bit_d = bit_q + 3'd1;
                    if (bit_q == 3'd3) advance = 1'b1;
                end
            end
            ST_GATHER: begin
                if (si_valid) begin
                    code_d = code_nxt;
                    bit_d  = bit_q + 3'd1;
                    if ((bit_q + 3'd1) == cur_width) begin
                        seg_d   = lut_hit ? lut_seg : '0;
                        err_d   = err_q | !lut_hit;
                        bit_d   = '0;
                        state_d = ST_DRAIN;
                    end
                end
            end
            ST_DRAIN: begin
                bit_d = bit_q + 3'd1;
                if (bit_q == 3'd3) advance = 1'b1;
            end
            ST_RESID: begin
                if (si_valid) begin
                    bit_d = bit_q + 3'd1;
                    if ((bit_q + 3'd1) == {1'b0, resid_q}) state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (advance) begin
            bit_d  = '0;
            code_d = '0;
            if (left_q > ONE_L) begin
                col_d   = col_q + 1'b1;
                left_d  = left_q - ONE_L;
                state_d = col_entry;
            end else begin
                left_d  = '0;
                state_d = (resid_q != '0) ? ST_RESID : ST_DONE;
            end
        end
    end

    // outputs
    always_comb begin
        si_ready = 1'b0;
        so_valid = 1'b0;
        so_data  = si_data;
        seg_done = 1'b0;
        pat_done = 1'b0;
        cfg_open = 1'b0;
        unique case (state_q)
            ST_IDLE:   cfg_open = 1'b1;
            ST_PASS:   begin si_ready = 1'b1; so_valid = si_valid; end
            ST_RAW:    begin
                si_ready = 1'b1;
                so_valid = si_valid;
                seg_done = si_valid && (bit_q == 3'd3);
            end
            ST_RESID:  begin si_ready = 1'b1; so_valid = si_valid; end
            ST_GATHER: si_ready = 1'b1;
            ST_DRAIN:  begin
                so_valid = 1'b1;
                so_data  = seg_q[2'd3 - bit_q[1:0]];
                seg_done = (bit_q == 3'd3);
            end
            ST_DONE:   pat_done = 1'b1;
            default:   cfg_open = 1'b0;
        endcase
    end

    assign rd_col  = col_q;
    assign rd_code = code_nxt;
    assign pk_col  = (state_q == ST_IDLE) ? '0 : COL_AW'(col_q + 1'b1);
    assign dec_err = err_q;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!so_valid && !si_ready));
    assert_pass_noseg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS) |-> !seg_done);
    assert_drain_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> !si_ready);
    assert_segdone_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seg_done |-> so_valid);
    assert_patdone_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pat_done |=> !pat_done);
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |=> dec_err);
    assert_no_fire_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (si_ready && !si_valid && (state_q != ST_GATHER)) |-> !so_valid);

endmodule

// File: rtl/scan_decomp.sv
module scan_decomp
    import dcmp_pkg::*;
#(
    parameter int N_COLS     = 16,
    parameter int CODE_W_MAX = 3,
    localparam int COL_AW    = $clog2(N_COLS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_width_we,
    input  logic                  cfg_lut_we,
    input  logic [COL_AW-1:0]     cfg_col,
    input  logic [2:0]            cfg_width,
    input  logic [CODE_W_MAX-1:0] cfg_code,
    input  logic [3:0]            cfg_seg,
    input  logic                  pat_start,
    input  logic                  pat_compress,
    input  logic [COL_AW:0]       pat_cols,
    input  logic [1:0]            pat_resid,
    input  logic                  si_valid,
    input  logic                  si_data,
    output logic                  si_ready,
    output logic                  so_valid,
    output logic                  so_data,
    output logic                  seg_done,
    output logic                  pat_done,
    output logic                  dec_err
);

    logic                  cfg_open;
    logic [COL_AW-1:0]     rd_col, pk_col;
    logic [CODE_W_MAX-1:0] rd_code;
    logic [WID_W-1:0]      cur_width, pk_width;
    logic [SEG_W-1:0]      lut_seg;
    logic                  lut_hit;

    dcmp_tables #(.N_COLS(N_COLS), .CODE_W_MAX(CODE_W_MAX)) u_tables (
        .clk(clk), .rst_n(rst_n), .cfg_open(cfg_open),
        .width_we(cfg_width_we), .lut_we(cfg_lut_we),
        .cfg_col(cfg_col), .cfg_width(cfg_width), .cfg_code(cfg_code), .cfg_seg(cfg_seg),
        .rd_col(rd_col), .rd_code(rd_code), .pk_col(pk_col),
        .cur_width(cur_width), .pk_width(pk_width),
        .lut_seg(lut_seg), .lut_hit(lut_hit)
    );

    dcmp_ctrl #(.N_COLS(N_COLS), .CODE_W_MAX(CODE_W_MAX)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .pat_start(pat_start), .pat_compress(pat_compress),
        .pat_cols(pat_cols), .pat_resid(pat_resid),
        .si_valid(si_valid), .si_data(si_data),
        .cur_width(cur_width), .pk_width(pk_width),
        .lut_seg(lut_seg), .lut_hit(lut_hit),
        .rd_col(rd_col), .pk_col(pk_col), .rd_code(rd_code),
        .cfg_open(cfg_open), .si_ready(si_ready),
        .so_valid(so_valid), .so_data(so_data),
        .seg_done(seg_done), .pat_done(pat_done), .dec_err(dec_err)
    );

endmodule

// File: tb/tb_scan_decomp.sv
module tb_scan_decomp;

    localparam int CLK_P = 10;
    localparam int NC    = 4;
    localparam int CW    = 3;
    localparam int CA    = $clog2(NC);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_width_we = 1'b0, cfg_lut_we = 1'b0;
    logic [CA-1:0] cfg_col = '0;
    logic [2:0]    cfg_width = '0;
    logic [CW-1:0] cfg_code = '0;
    logic [3:0]    cfg_seg = '0;
    logic          pat_start = 1'b0, pat_compress = 1'b0;
    logic [CA:0]   pat_cols = '0;
    logic [1:0]    pat_resid = '0;
    logic          si_valid = 1'b0, si_data = 1'b0;
    logic          si_ready, so_valid, so_data, seg_done, pat_done, dec_err;

    scan_decomp #(.N_COLS(NC), .CODE_W_MAX(CW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_width_we(cfg_width_we), .cfg_lut_we(cfg_lut_we),
        .cfg_col(cfg_col), .cfg_width(cfg_width), .cfg_code(cfg_code), .cfg_seg(cfg_seg),
        .pat_start(pat_start), .pat_compress(pat_compress),
        .pat_cols(pat_cols), .pat_resid(pat_resid),
        .si_valid(si_valid), .si_data(si_data), .si_ready(si_ready),
        .so_valid(so_valid), .so_data(so_data),
        .seg_done(seg_done), .pat_done(pat_done), .dec_err(dec_err)
    );

    always #(CLK_P/2) clk = ~clk;

    int   nchk = 0, nerr = 0;
    int   bw [0:NC-1];
    bit   ld [0:NC-1][0:7];
    bit   err_exp = 1'b0;
    logic in_bits [0:255];
    logic exp_bits [0:255];
    logic out_bits [0:255];
    int   nin, nexp, nout, nseg, ncyc, npd, exp_seg, exp_cyc;

    function automatic logic [3:0] seg_of(input int c, input int code);
        return 4'((code * 7 + c * 5 + 3) % 16);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic push_both(input logic b);
        in_bits[nin] = b;  nin++;
        exp_bits[nexp] = b; nexp++;
    endtask

    task automatic push_nib(input logic [3:0] v);
        for (int b = 3; b >= 0; b--) push_both(v[b]);
    endtask

    // build stimulus and expected stream from the requirements
    task automatic build(input bit comp, input int ncol, input int nres, input int k);
        nin = 0; nexp = 0; exp_seg = 0; exp_cyc = 1;
        for (int c = 0; c < ncol; c++) begin
            if (comp && bw[c] >= 1 && bw[c] <= CW) begin
                int code;
                logic [3:0] s;
                code = k % (1 << bw[c]);
                for (int b = bw[c] - 1; b >= 0; b--) begin
                    in_bits[nin] = 1'((code >> b) & 1); nin++;
                end
                s = ld[c][code] ? seg_of(c, code) : 4'h0;
                if (!ld[c][code]) err_exp = 1'b1;
                for (int b = 3; b >= 0; b--) begin
                    exp_bits[nexp] = s[b]; nexp++;
                end
                exp_cyc += bw[c] + 4;
                exp_seg++;
            end else begin
                push_nib(4'((k * 11 + c * 7 + 5) % 16));
                exp_cyc += 4;
                if (comp) exp_seg++;
            end
        end
        for (int r = 0; r < nres; r++) push_both(1'((k + r + 1) % 2));
        exp_cyc += nres;
    endtask

    task automatic run(input bit comp, input int ncol, input int nres,
                       input bit bubble, input bit poke);
        int ptr;
        int cyc;
        bit fin;
        @(negedge clk);
        pat_start = 1'b1; pat_compress = comp;
        pat_cols = (CA+1)'(ncol); pat_resid = 2'(nres);
        si_valid = 1'b0;
        @(negedge clk);
        pat_start = 1'b0;
        ptr = 0; cyc = 0; fin = 1'b0;
        nout = 0; nseg = 0; npd = 0;
        while (!fin && cyc < 2000) begin
            cyc++;
            si_valid = (ptr < nin) && !(bubble && (cyc % 3 == 0));
            si_data  = (ptr < nin) ? in_bits[ptr] : 1'b0;
            if (poke && cyc == 2) begin
                cfg_lut_we = 1'b1; cfg_width_we = 1'b1;
                cfg_col = '0; cfg_code = '0; cfg_width = 3'd4;
                cfg_seg = ~seg_of(0, 0);
                pat_start = 1'b1;
            end else begin
                cfg_lut_we = 1'b0; cfg_width_we = 1'b0; pat_start = 1'b0;
            end
            #1;
            if (so_valid) begin out_bits[nout] = so_data; nout++; end
            if (seg_done) nseg++;
            if (pat_done) begin npd++; fin = 1'b1; end
            if (si_valid && si_ready) ptr++;
            @(negedge clk);
        end
        si_valid = 1'b0; cfg_lut_we = 1'b0; cfg_width_we = 1'b0; pat_start = 1'b0;
        ncyc = cyc;
        #1;
        if (pat_done) npd++;
    endtask

    task automatic verify(input string tag, input string ctag, input bit comp, input bit bubble);
        int mism;
        int first;
        mism = 0; first = -1;
        for (int i = 0; i < nexp && i < nout; i++) begin
            if (out_bits[i] !== exp_bits[i]) begin
                mism++;
                if (first < 0) first = i;
            end
        end
        check(nout == nexp, tag, "output bit count", nout, nexp);
        check(mism == 0, tag, "first mismatching bit index", first, -1);
        check(nseg == exp_seg, comp ? "R7" : "R2", "seg_done pulses", nseg, exp_seg);
        check(npd == 1, "R8", "pat_done pulses", npd, 1);
        if (!bubble) check(ncyc == exp_cyc, ctag, "cycles to pat_done", ncyc, exp_cyc);
        check(dec_err === err_exp, "R9", "dec_err", int'(dec_err), int'(err_exp));
    endtask

    task automatic write_width(input int c, input int w);
        @(negedge clk);
        cfg_width_we = 1'b1; cfg_col = CA'(c); cfg_width = 3'(w);
        @(negedge clk);
        cfg_width_we = 1'b0;
        bw[c] = w;
    endtask

    task automatic write_lut(input int c, input int code, input logic [3:0] s);
        @(negedge clk);
        cfg_lut_we = 1'b1; cfg_col = CA'(c); cfg_code = CW'(code); cfg_seg = s;
        @(negedge clk);
        cfg_lut_we = 1'b0;
        ld[c][code] = 1'b1;
    endtask

    task automatic model_reset();
        err_exp = 1'b0;
        for (int c = 0; c < NC; c++) begin
            bw[c] = 0;
            for (int e = 0; e < 8; e++) ld[c][e] = 1'b0;
        end
    endtask

    task automatic check_reset_outputs();
        check(si_ready == 1'b0, "R1", "si_ready", int'(si_ready), 0);
        check(so_valid == 1'b0, "R1", "so_valid", int'(so_valid), 0);
        check(seg_done == 1'b0 && pat_done == 1'b0, "R1", "done flags",
              int'({seg_done, pat_done}), 0);
        check(dec_err == 1'b0, "R1", "dec_err", int'(dec_err), 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check_reset_outputs();

        // R5: after reset all widths are 0, so compressed columns are raw
        build(1'b1, 2, 1, 3);
        run(1'b1, 2, 1, 1'b0, 1'b0);
        verify("R5", "R4", 1'b1, 1'b0);

        // column tables: widths 1,2,3 coded, 4 raw; col2 code 5 left unloaded
        write_width(0, 1); write_width(1, 2); write_width(2, 3); write_width(3, 4);
        for (int c = 0; c < 3; c++)
            for (int e = 0; e < 8; e++)
                if (!(c == 2 && e == 5)) write_lut(c, e, seg_of(c, e));

        // R8: empty pattern
        build(1'b1, 0, 0, 0);
        run(1'b1, 0, 0, 1'b0, 1'b0);
        check(nout == 0, "R8", "bits from empty pattern", nout, 0);
        check(npd == 1 && ncyc == 1, "R8", "empty pattern done cycle", ncyc, 1);

        // R2: bypass patterns, with and without gaps (R11)
        build(1'b0, 4, 3, 1);
        run(1'b0, 4, 3, 1'b0, 1'b0);
        verify("R2", "R2", 1'b0, 1'b0);
        build(1'b0, 2, 0, 6);
        run(1'b0, 2, 0, 1'b1, 1'b0);
        verify("R11", "R2", 1'b0, 1'b1);

        // R10: writes and a second start during a pattern are ignored
        build(1'b1, 4, 2, 2);
        run(1'b1, 4, 2, 1'b0, 1'b1);
        verify("R10", "R4", 1'b1, 1'b0);

        // R3/R6/R9: sweep every code of every coded column
        for (int k = 0; k < 8; k++) begin
            bit bub;
            bub = (k % 2) == 1;
            build(1'b1, 4, k % 4, k);
            run(1'b1, 4, k % 4, bub, 1'b0);
            verify((k % 4 != 0) ? "R6" : "R3", "R4", 1'b1, bub);
        end
        check(err_exp == 1'b1, "R9", "sweep reached unloaded code", int'(err_exp), 1);

        // R5: walk column 0 through every width field value
        for (int w = 0; w < 8; w++) begin
            write_width(0, w);
            build(1'b1, 1, 0, w);
            run(1'b1, 1, 0, 1'b0, 1'b0);
            verify((w >= 1 && w <= CW) ? "R3" : "R5", "R4", 1'b1, 1'b0);
        end

        // R1/R9: reset clears the sticky error and the tables
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        #1;
        check_reset_outputs();

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule